// File: doc/BRIEF.md
# Scalar Float Compare Flag Generator

This block compares the lowest single-precision lane of two 128-bit operands. It returns processor status flags, not a data word. The pair is sorted into one of four ordering classes: unordered, greater, less or equal. Each class drives the zero, parity and carry flags to a fixed three-bit code. The overflow, sign and auxiliary-carry flags are driven to zero on every compare.

A one-cycle start strobe captures the two operands. The flags and a one-cycle done pulse appear on the next clock edge. The flags then hold until the next start. A signalling NaN on either side does not raise an exception. It sets a sticky invalid indicator, which only a synchronous clear input drops.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Only bits 31:0 of each operand take part in the compare; bits 127:32 of both operands have no effect on any output.
- R2: If either low lane is a NaN (exponent bits 30:23 all ones, fraction bits 22:0 nonzero), quiet or signalling, the result is unordered and {zf_o, pf_o, cf_o} = 3'b111.
- R3: When the dst_i lane is greater than the src_i lane, {zf_o, pf_o, cf_o} = 3'b000.
- R4: When the dst_i lane is less than the src_i lane, {zf_o, pf_o, cf_o} = 3'b001.
- R5: When the two lanes are equal, {zf_o, pf_o, cf_o} = 3'b100. Positive and negative zero count as equal, and pf_o is set only in the unordered code.
- R6: of_o, sf_o and af_o are 0 after every compare.
- R7: Flags update and done_o rises exactly one clock after a cycle with start_i high. done_o is high only in that cycle. Without start_i the flags hold their value.
- R8: invalid_o is set one clock after a start in which either lane is a signalling NaN (exponent all ones, bit 22 clear, bits 21:0 nonzero). It stays set until a cycle with clr_invalid_i high. If start with a signalling NaN and clear arrive in the same cycle, the set wins.
- R9: Infinities compare as ordered values. +inf is greater than every finite value, -inf is less than every finite value, and equal infinities give the equal code.
- R10: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Compare strobe, one cycle |
| clr_invalid_i | input | 1 | Synchronous clear of the sticky invalid flag |
| dst_i | input | 128 | Destination-side operand; only bits 31:0 are used |
| src_i | input | 128 | Source-side operand; only bits 31:0 are used |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag, always cleared |
| sf_o | output | 1 | Sign flag, always cleared |
| af_o | output | 1 | Auxiliary-carry flag, always cleared |
| done_o | output | 1 | One-cycle pulse when the flags are valid |
| invalid_o | output | 1 | Sticky signalling-NaN indicator |

## Verification
Ordinary finite pairs of like and unlike sign are compared in both directions. These separate the greater and less codes, and show whether the magnitude order is reversed for negative values. Signed zeros, neighbouring tiny denormals, and infinities against the largest finite value test the edges of that ordering. Quiet and signalling NaNs placed on each side in turn separate the unordered code from the sticky invalid path. Every vector carries NaN-like garbage in the upper 96 bits to show that those bits are ignored. Directed runs then test hold without start, sticky persistence, and the priority of set over clear.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } op_info_t;

  // {zf, pf, cf} per ordering class
  function automatic logic [2:0] flag_code(cmp_res_e r);
    logic [2:0] c;
    case (r)
      CMP_UN:  c = 3'b111;
      CMP_LT:  c = 3'b001;
      CMP_EQ:  c = 3'b100;
      default: c = 3'b000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int LANE_W = EXP_W + MAN_W + 1
) (
  input  logic [LANE_W-1:0] lane_i,
  output op_info_t          info_o,
  output logic [LANE_W-2:0] mag_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             man_nz;

  assign exp_f   = lane_i[LANE_W-2 -: EXP_W];
  assign man_f   = lane_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    info_o.sign    = lane_i[LANE_W-1];
    info_o.is_nan  = exp_max && man_nz;
    // quiet bit is the top fraction bit
    info_o.is_snan = exp_max && man_nz && !man_f[MAN_W-1];
    info_o.is_zero = ~|lane_i[LANE_W-2:0];
  end

  assign mag_o = lane_i[LANE_W-2:0];

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  op_info_t          a_info_i,
  input  op_info_t          b_info_i,
  input  logic [LANE_W-2:0] a_mag_i,
  input  logic [LANE_W-2:0] b_mag_i,
  output cmp_res_e          res_o
);

  logic mag_gt;
  logic mag_eq;

  assign mag_gt = a_mag_i > b_mag_i;
  assign mag_eq = a_mag_i == b_mag_i;

  always_comb begin
    if (a_info_i.is_nan || b_info_i.is_nan) begin
      res_o = CMP_UN;
    end else if (a_info_i.is_zero && b_info_i.is_zero) begin
      res_o = CMP_EQ;
    end else if (a_info_i.sign != b_info_i.sign) begin
      res_o = a_info_i.sign ? CMP_LT : CMP_GT;
    end else if (mag_eq) begin
      res_o = CMP_EQ;
    end else if (mag_gt ^ a_info_i.sign) begin
      // larger magnitude wins for positive, loses for negative
      res_o = CMP_GT;
    end else begin
      res_o = CMP_LT;
    end
  end

endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg
  import fcmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     clr_invalid_i,
  input  cmp_res_e res_i,
  input  logic     snan_i,
  output logic     zf_o,
  output logic     pf_o,
  output logic     cf_o,
  output logic     of_o,
  output logic     sf_o,
  output logic     af_o,
  output logic     done_o,
  output logic     invalid_o
);

  logic [2:0] code_q;
  logic [2:0] clr_q;
  logic       done_q;
  logic       inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      clr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        code_q <= flag_code(res_i);
        clr_q  <= '0;
      end
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                inv_q <= 1'b0;
    else if (start_i && snan_i) inv_q <= 1'b1;
    else if (clr_invalid_i)     inv_q <= 1'b0;
  end

  assign {zf_o, pf_o, cf_o} = code_q;
  assign {of_o, sf_o, af_o} = clr_q;
  assign done_o             = done_q;
  assign invalid_o          = inv_q;

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  localparam int LANE_W = EXP_W + MAN_W + 1,
  localparam int N_OPS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clr_invalid_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              zf_o,
  output logic              pf_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              af_o,
  output logic              done_o,
  output logic              invalid_o
);

  logic [N_OPS-1:0][LANE_W-1:0] lane;
  logic [N_OPS-1:0][LANE_W-2:0] mag;
  op_info_t [N_OPS-1:0]         info;
  cmp_res_e                     res;
  logic                         any_snan;
  logic                         unused_upper;

  assign lane[0] = dst_i[LANE_W-1:0];
  assign lane[1] = src_i[LANE_W-1:0];
  assign unused_upper = ^{dst_i[DATA_W-1:LANE_W], src_i[DATA_W-1:LANE_W]};

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fcmp_classify #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) u_cls (
      .lane_i(lane[g]),
      .info_o(info[g]),
      .mag_o (mag[g])
    );
  end

  fcmp_order #(
    .LANE_W(LANE_W)
  ) u_order (
    .a_info_i(info[0]),
    .b_info_i(info[1]),
    .a_mag_i (mag[0]),
    .b_mag_i (mag[1]),
    .res_o   (res)
  );

  assign any_snan = info[0].is_snan || info[1].is_snan;

  fcmp_flag_reg u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .clr_invalid_i(clr_invalid_i),
    .res_i        (res),
    .snan_i       (any_snan),
    .zf_o         (zf_o),
    .pf_o         (pf_o),
    .cf_o         (cf_o),
    .of_o         (of_o),
    .sf_o         (sf_o),
    .af_o         (af_o),
    .done_o       (done_o),
    .invalid_o    (invalid_o)
  );

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk #(
  parameter int DATA_W = 128,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              clr_invalid_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic              zf_o,
  input logic              pf_o,
  input logic              cf_o,
  input logic              of_o,
  input logic              sf_o,
  input logic              af_o,
  input logic              done_o,
  input logic              invalid_o
);

  logic dst_nan;
  logic src_nan;
  assign dst_nan = (&dst_i[EXP_W+MAN_W-1:MAN_W]) && (|dst_i[MAN_W-1:0]);
  assign src_nan = (&src_i[EXP_W+MAN_W-1:MAN_W]) && (|src_i[MAN_W-1:0]);

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R7
  AST_DONE_ONLY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable({zf_o, pf_o, cf_o})); // R7
  AST_NAN_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (dst_nan || src_nan) |=> zf_o && pf_o && cf_o); // R2
  AST_PF_ONLY_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_o |-> zf_o && cf_o); // R5
  AST_AUX_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !of_o && !sf_o && !af_o); // R6
  AST_INV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o && !clr_invalid_i |=> invalid_o); // R8
  AST_INV_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_invalid_i && !start_i |=> !invalid_o); // R8

endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk #(
  .DATA_W(DATA_W),
  .EXP_W (EXP_W),
  .MAN_W (MAN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .clr_invalid_i(clr_invalid_i),
  .dst_i        (dst_i),
  .src_i        (src_i),
  .zf_o         (zf_o),
  .pf_o         (pf_o),
  .cf_o         (cf_o),
  .of_o         (of_o),
  .sf_o         (sf_o),
  .af_o         (af_o),
  .done_o       (done_o),
  .invalid_o    (invalid_o)
);

// File: tb/fcmp_flag_unit_bench.sv
module fcmp_flag_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         clr_inv = 1'b0;
  logic [127:0] dst = '0;
  logic [127:0] src = '0;
  logic zf, pf, cf, of, sf, af, done, inv;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fcmp_flag_unit u_fcmp_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clr_invalid_i(clr_inv),
    .dst_i(dst), .src_i(src),
    .zf_o(zf), .pf_o(pf), .cf_o(cf), .of_o(of), .sf_o(sf), .af_o(af),
    .done_o(done), .invalid_o(inv)
  );

  // {dst lane, src lane, {zf,pf,cf}, snan expected}
  localparam int NV = 19;
  localparam logic [67:0] VEC [NV] = '{
    {32'h3F800000, 32'h40000000, 3'b001, 1'b0}, // R4  1 < 2
    {32'h40000000, 32'h3F800000, 3'b000, 1'b0}, // R3  2 > 1
    {32'h3F800000, 32'h3F800000, 3'b100, 1'b0}, // R5
    {32'h00000000, 32'h80000000, 3'b100, 1'b0}, // R5 +0 = -0
    {32'h80000000, 32'h00000000, 3'b100, 1'b0}, // R5 -0 = +0
    {32'hBF800000, 32'h3F800000, 3'b001, 1'b0}, // R4 -1 < 1
    {32'hC0000000, 32'hBF800000, 3'b001, 1'b0}, // R4 -2 < -1
    {32'hBF800000, 32'hC0000000, 3'b000, 1'b0}, // R3 -1 > -2
    {32'h7F800000, 32'h7F7FFFFF, 3'b000, 1'b0}, // R9 +inf > max
    {32'hFF800000, 32'hFF7FFFFF, 3'b001, 1'b0}, // R9 -inf < -max
    {32'h7F800000, 32'h7F800000, 3'b100, 1'b0}, // R9 inf = inf
    {32'h7FC00000, 32'h3F800000, 3'b111, 1'b0}, // R2 qnan dst
    {32'h3F800000, 32'h7FC00000, 3'b111, 1'b0}, // R2 qnan src
    {32'h7F800001, 32'h3F800000, 3'b111, 1'b1}, // R2 R8 snan dst
    {32'h3F800000, 32'hFF800001, 3'b111, 1'b1}, // R2 R8 snan src
    {32'h00000001, 32'h80000001, 3'b000, 1'b0}, // R3 denorm sign
    {32'h00000001, 32'h00000000, 3'b000, 1'b0}, // R3 denorm > 0
    {32'hFFC00000, 32'hFF800000, 3'b111, 1'b0}, // R2 neg qnan
    {32'h7F800000, 32'hFF800000, 3'b000, 1'b0}  // R9 +inf > -inf
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic do_cmp(input logic [127:0] d, input logic [127:0] s, input logic clr);
    dst = d; src = s; start = 1'b1; clr_inv = clr;
    @(negedge clk);
    start = 1'b0; clr_inv = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [95:0] junk;
    // R10 reset state
    repeat (2) @(negedge clk);
    check("R10", "outputs in reset", {24'd0, zf, pf, cf, of, sf, af, done, inv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      // R1: NaN-like garbage in upper lanes
      junk = {32'h7FC00001 ^ i, 32'hFF800001, 32'h7F800000 + i};
      do_cmp({junk, VEC[i][67:36]}, {~junk, VEC[i][35:4]}, 1'b1);
      check("R7", $sformatf("vec %0d done", i), {31'd0, done}, 32'd1);
      check("R2-5,9", $sformatf("vec %0d zpc", i), {29'd0, zf, pf, cf}, {29'd0, VEC[i][3:1]});
      check("R6", $sformatf("vec %0d of/sf/af", i), {29'd0, of, sf, af}, 32'd0);
      check("R8", $sformatf("vec %0d invalid", i), {31'd0, inv}, {31'd0, VEC[i][0]});
    end

    // R7 done is a single pulse, flags hold without start
    do_cmp({96'd0, 32'h3F800000}, {96'd0, 32'h40000000}, 1'b0);
    dst = {96'd0, 32'h7FC00000}; src = '0;
    @(negedge clk);
    check("R7", "done pulse drop", {31'd0, done}, 32'd0);
    check("R7", "flags hold", {29'd0, zf, pf, cf}, 32'b001);
    repeat (3) @(negedge clk);
    check("R7", "flags hold later", {29'd0, zf, pf, cf}, 32'b001);

    // R1 directed: same low lane, different upper bits
    do_cmp({96'h0, 32'h40400000}, {96'h0, 32'h40000000}, 1'b0);
    check("R1", "upper zero", {29'd0, zf, pf, cf}, 32'b000);
    do_cmp({{3{32'hFFFFFFFF}}, 32'h40400000}, {{3{32'h7FC00000}}, 32'h40000000}, 1'b0);
    check("R1", "upper ones", {29'd0, zf, pf, cf}, 32'b000);

    // R8 sticky behaviour
    do_cmp({96'd0, 32'h7F800001}, '0, 1'b1);
    check("R8", "set", {31'd0, inv}, 32'd1);
    do_cmp({96'd0, 32'h3F800000}, {96'd0, 32'h3F800000}, 1'b0);
    check("R8", "sticky over clean compare", {31'd0, inv}, 32'd1);
    check("R5", "clean compare after snan", {29'd0, zf, pf, cf}, 32'b100);
    do_cmp({96'd0, 32'h7FC00000}, '0, 1'b0);
    check("R8", "qnan does not affect", {31'd0, inv}, 32'd1);
    clr_inv = 1'b1;
    @(negedge clk);
    clr_inv = 1'b0;
    check("R8", "clear alone", {31'd0, inv}, 32'd0);
    check("R7", "clear does not touch flags", {29'd0, zf, pf, cf}, 32'b111);
    do_cmp({96'd0, 32'h3F800000}, {96'd0, 32'hFFA00000}, 1'b1);
    check("R8", "set wins over clear", {31'd0, inv}, 32'd1);

    // R10 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "outputs after reset", {24'd0, zf, pf, cf, of, sf, af, done, inv}, 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule